// File: doc/BRIEF.md
# Microprogram Sequencer with Restart Watchdog

This block steps through a read-only control store of 544 bytes and turns each two-byte instruction into a control action for a token-passing network engine. One fast clock drives it. An internal phase bit splits that clock into alternating fetch and execute cycles, so the program counter moves on every fast cycle while instructions complete at half that rate. The first byte of an instruction goes into an opcode register and the second byte goes into an immediate register. The decoder then acts on the pair: it emits a control byte, takes a branch, waits out a timed delay, or does nothing.

A controller state machine runs the block. It has three states. FETCH_OP loads the opcode. FETCH_IMM loads the immediate and executes the instruction. DELAY holds the counter while a no-op timer runs. The transitions are:
- FETCH_OP to FETCH_IMM, always.
- FETCH_IMM to DELAY, for a no-op with a non-zero count.
- FETCH_IMM to FETCH_OP, for every other instruction.
- DELAY to FETCH_OP, when the count is spent.
- Any state to FETCH_OP, when the reconfiguration timer expires.

A timer expiry also clears the program counter and sets a sticky status flag. That flag stays set until a clear pulse or a reset.

Top module: `mseq_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the outputs read as follows: pc is 0, op_reg, imm_reg and ctrl_out are 0, exec_en is 0 and recon_flag is 0.
- R2: exec_en toggles on every clock edge and is low in the cycle after reset. The opcode byte is fetched in a cycle with exec_en low and the immediate byte in the following cycle with exec_en high. Each fetch advances pc by one.
- R3: The opcode encodings are 0x00 for a no-op, 0x01 for a jump and 0x02 for an output. An output instruction loads ctrl_out with its immediate at the edge that ends its execute cycle. Any other opcode has no effect beyond advancing pc.
- R4: A jump sets pc to twice its immediate value, at the edge that ends its execute cycle.
- R5: A no-op with immediate N greater than 0 advances pc past the immediate byte and then holds it for 2*N clock cycles before the next opcode fetch. A no-op with N equal to 0 adds no cycles.
- R6: pc counts from 543 to 0. Any computed address at or above 544 becomes 0.
- R7: A recon_expire pulse sets pc to 0, sets recon_flag and restarts the opcode fetch, with exec_en low in the next cycle. This overrides any jump, delay or fetch in progress.
- R8: recon_flag stays set until a cycle with flag_clear high and recon_expire low. When both inputs are high in the same cycle, the flag is set.
- R9: The control store is laid out by byte address as follows:
  - 0: output 0xA5
  - 2: no-op 3
  - 4: output 0x3C
  - 6: no-op 0
  - 8: jump 8
  - 10: output 0xFF
  - 16: output 0x5A
  - 18: jump 0xF8
  - Every other even byte holds 0x04. Every other odd byte holds the low 8 bits of its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recon_expire | input | 1 | Reconfiguration timer expiry pulse |
| flag_clear | input | 1 | Clears the sticky reconfiguration flag |
| exec_en | output | 1 | Half-rate execute phase |
| pc | output | 10 | Program counter |
| op_reg | output | 8 | Opcode register |
| imm_reg | output | 8 | Immediate register |
| ctrl_out | output | 8 | Decoded control byte |
| recon_flag | output | 1 | Sticky reconfiguration status |

## Verification
Two functions can land in the same cycle. A timer expiry can meet a jump, a delay countdown or an opcode fetch, and it can also meet a flag clear. The bench fixes one cycle in which recon_expire and flag_clear are both raised, and it also raises both inputs at random against the running microprogram. A cycle-level reference model judges each outcome. The model requires that the expiry wins in both conflicts: pc returns to 0 and the flag reads set. The restarted fetch must also land on the low phase.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    typedef enum logic [1:0] {
        S_FETCH_OP  = 2'd0,
        S_FETCH_IMM = 2'd1,
        S_DELAY     = 2'd2
    } seq_state_e;

    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [7:0] OP_JUMP = 8'h01;
    localparam logic [7:0] OP_OUT  = 8'h02;
    localparam logic [7:0] OP_FILL = 8'h04;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
    parameter int unsigned DEPTH = 544,
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 8
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    import mseq_pkg::*;

    always_comb begin
        if (32'(addr) >= DEPTH) begin
            data = '0;
        end else begin
            unique case (addr)
                AW'(0):  data = DW'(OP_OUT);
                AW'(1):  data = DW'(8'hA5);
                AW'(2):  data = DW'(OP_NOP);
                AW'(3):  data = DW'(8'h03);
                AW'(4):  data = DW'(OP_OUT);
                AW'(5):  data = DW'(8'h3C);
                AW'(6):  data = DW'(OP_NOP);
                AW'(7):  data = DW'(8'h00);
                AW'(8):  data = DW'(OP_JUMP);
                AW'(9):  data = DW'(8'h08);
                AW'(10): data = DW'(OP_OUT);
                AW'(11): data = DW'(8'hFF);
                AW'(16): data = DW'(OP_OUT);
                AW'(17): data = DW'(8'h5A);
                AW'(18): data = DW'(OP_JUMP);
                AW'(19): data = DW'(8'hF8);
                default: data = addr[0] ? DW'(addr[7:0]) : DW'(OP_FILL);
            endcase
        end
    end
endmodule

// File: rtl/mseq_phase.sv
module mseq_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic exec_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       exec_en <= 1'b0;
        else if (restart) exec_en <= 1'b0;
        else              exec_en <= ~exec_en;
    end

    // R2: phase alternates unless a restart realigns it
    p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !exec_en) |=> exec_en);
    p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> !exec_en);
endmodule

// File: rtl/mseq_flag.sv
module mseq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R8: set dominates, flag is sticky without a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
#(
    parameter int unsigned DEPTH = 544,
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          recon_expire,
    input  logic          flag_clear,
    output logic          exec_en,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] op_reg,
    output logic [DW-1:0] imm_reg,
    output logic [DW-1:0] ctrl_out,
    output logic          recon_flag
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    seq_state_e    state_q, state_d;
    logic [DW-1:0] store_data;
    logic [DW-1:0] cnt_q;
    logic [AW-1:0] pc_inc;
    logic [AW:0]   jmp_raw;
    logic [AW-1:0] jmp_tgt;

    mseq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .addr (pc),
        .data (store_data)
    );

    mseq_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (recon_expire),
        .exec_en (exec_en)
    );

    mseq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (recon_expire),
        .clr   (flag_clear),
        .flag  (recon_flag)
    );

    // Address arithmetic with wrap at the store boundary
    always_comb begin
        pc_inc  = (pc >= LAST) ? '0 : pc + AW'(1);
        jmp_raw = (AW+1)'({store_data, 1'b0});
        jmp_tgt = (32'(jmp_raw) >= DEPTH) ? '0 : jmp_raw[AW-1:0];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FETCH_OP;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (recon_expire) begin
            state_d = S_FETCH_OP;
        end else begin
            unique case (state_q)
                S_FETCH_OP:  state_d = S_FETCH_IMM;
                S_FETCH_IMM: state_d = (op_reg == DW'(OP_NOP) && store_data != '0)
                                       ? S_DELAY : S_FETCH_OP;
                S_DELAY:     if (exec_en && cnt_q == DW'(1)) state_d = S_FETCH_OP;
                default:     state_d = S_FETCH_OP;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            op_reg   <= '0;
            imm_reg  <= '0;
            ctrl_out <= '0;
            cnt_q    <= '0;
        end else if (recon_expire) begin
            pc <= '0;
        end else begin
            unique case (state_q)
                S_FETCH_OP: begin
                    op_reg <= store_data;
                    pc     <= pc_inc;
                end
                S_FETCH_IMM: begin
                    imm_reg <= store_data;
                    if (op_reg == DW'(OP_JUMP)) begin
                        pc <= jmp_tgt;
                    end else begin
                        pc <= pc_inc;
                        if (op_reg == DW'(OP_NOP)) cnt_q    <= store_data;
                        if (op_reg == DW'(OP_OUT)) ctrl_out <= store_data;
                    end
                end
                S_DELAY: begin
                    if (exec_en) cnt_q <= cnt_q - DW'(1);
                end
                default: ;
            endcase
        end
    end

    // R7: expiry clears pc, realigns phase, raises the flag
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recon_expire |=> (pc == '0 && !exec_en && recon_flag));
    // R5: counter frozen throughout the delay loop
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DELAY && !recon_expire) |=> $stable(pc));
    // R2: opcode fetch lands on the low phase
    p_fetch_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_OP) |-> !exec_en);
    // R4: jump loads twice the immediate
    p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_IMM && op_reg == DW'(OP_JUMP) && !recon_expire)
        |=> (32'(pc) == 2 * 32'($past(store_data)) || 2 * 32'($past(store_data)) >= DEPTH));
    // R6: pc never leaves the store
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pc) < DEPTH);
endmodule

// File: tb/mseq_core_tb.sv
module mseq_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exp_i = 1'b0;
    logic       clr_i = 1'b0;
    logic       exec_en;
    logic [9:0] pc;
    logic [7:0] op_reg, imm_reg, ctrl_out;
    logic       recon_flag;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Reference model state
    int m_pc, m_st, m_op, m_imm, m_ctrl, m_cnt;
    bit m_ph, m_flag;
    bit seen_ff = 0;

    always #5 clk = ~clk;

    mseq_core u_dut (
        .clk (clk), .rst_n (rst_n), .recon_expire (exp_i), .flag_clear (clr_i),
        .exec_en (exec_en), .pc (pc), .op_reg (op_reg), .imm_reg (imm_reg),
        .ctrl_out (ctrl_out), .recon_flag (recon_flag)
    );

    function automatic int store_byte(input int a);
        case (a)
            0: return 8'h02;  1: return 8'hA5;
            2: return 8'h00;  3: return 3;
            4: return 8'h02;  5: return 8'h3C;
            6: return 8'h00;  7: return 0;
            8: return 8'h01;  9: return 8;
            10: return 8'h02; 11: return 8'hFF;
            16: return 8'h02; 17: return 8'h5A;
            18: return 8'h01; 19: return 8'hF8;
            default: return (a % 2 == 1) ? (a % 256) : 8'h04;
        endcase
    endfunction

    function automatic int next_addr(input int a);
        return (a + 1 >= 544) ? 0 : a + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Cycle model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_st = 0; m_op = 0; m_imm = 0; m_ctrl = 0; m_cnt = 0;
            m_ph = 0; m_flag = 0;
        end else begin
            cyc++;
            if (exp_i) begin
                m_pc = 0; m_st = 0;
            end else begin
                case (m_st)
                    0: begin m_op = store_byte(m_pc); m_pc = next_addr(m_pc); m_st = 1; end
                    1: begin
                        m_imm = store_byte(m_pc);
                        m_st = 0;
                        if (m_op == 1) begin
                            m_pc = (2 * m_imm >= 544) ? 0 : 2 * m_imm;
                        end else begin
                            m_pc = next_addr(m_pc);
                            if (m_op == 2) m_ctrl = m_imm;
                            if (m_op == 0 && m_imm != 0) begin m_cnt = m_imm; m_st = 2; end
                        end
                    end
                    default: if (m_ph) begin
                        if (m_cnt == 1) m_st = 0; else m_cnt = m_cnt - 1;
                    end
                endcase
            end
            m_flag = exp_i ? 1'b1 : (clr_i ? 1'b0 : m_flag);
            m_ph   = exp_i ? 1'b0 : ~m_ph;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && cyc > 0 && !done) begin
            if (ctrl_out == 8'hFF && cyc < 80) seen_ff = 1;
            chk(int'(pc) == m_pc, "R2 pc trace", pc, m_pc);
            chk(exec_en == m_ph, "R2 phase", exec_en, m_ph);
            chk(int'(op_reg) == m_op && int'(imm_reg) == m_imm, "R3 instr regs",
                {op_reg, imm_reg}, m_op * 256 + m_imm);
            chk(int'(ctrl_out) == m_ctrl, "R3 ctrl_out", ctrl_out, m_ctrl);
            chk(recon_flag == m_flag, "R8 flag", recon_flag, m_flag);
            case (cyc)
                1:  chk(exec_en == 1'b1, "R2 exec high", exec_en, 1);
                2:  chk(ctrl_out == 8'hA5, "R3 first output", ctrl_out, 8'hA5);
                4:  chk(pc == 10'd4, "R5 delay entry", pc, 4);
                10: chk(pc == 10'd4, "R5 delay hold", pc, 4);
                11: chk(pc == 10'd5, "R5 resume", pc, 5);
                14: chk(pc == 10'd8, "R5 zero count", pc, 8);
                16: chk(pc == 10'd16, "R4 jump", pc, 16);
                18: chk(ctrl_out == 8'h5A, "R9 store byte", ctrl_out, 8'h5A);
                20: chk(pc == 10'd496, "R4 far jump", pc, 496);
                68: chk(pc == 10'd0, "R6 wrap", pc, 0);
                79: chk(!seen_ff, "R4 skipped output", seen_ff, 0);
                91: begin
                    chk(pc == 10'd0, "R7 restart", pc, 0);
                    chk(recon_flag == 1'b1, "R8 set over clear", recon_flag, 1);
                    chk(exec_en == 1'b0, "R7 phase realign", exec_en, 0);
                end
                default: ;
            endcase
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(pc == 10'd0 && op_reg == 8'd0 && imm_reg == 8'd0, "R1 reset regs", pc, 0);
        chk(ctrl_out == 8'd0 && !recon_flag && !exec_en, "R1 reset outputs", ctrl_out, 0);
        rst_n = 1'b1;
        while (cyc < 90) @(negedge clk);
        exp_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        exp_i = 1'b0; clr_i = 1'b0;
        // R7 R8 random conflicts with the running program
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            exp_i = ($urandom % 37 == 0);
            clr_i = ($urandom % 9 == 0);
        end
        @(negedge clk);
        exp_i = 1'b0; clr_i = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 4100);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule